// File: doc/BRIEF.md
# Two-Way Set-Associative Instruction Cache

This block sits between a processor's instruction fetch port and a slow main memory that is 64 bits wide. The processor presents a 32-bit byte address every cycle. The cache returns the addressed 32-bit instruction and raises a ready flag in the cycle the fetch completes. The cache is read-only. It holds two ways of 32 sets, each line two words wide. Each set has one replacement bit that records which way was least recently used.

A lookup reads both ways at the set named by address bits 7:3 and compares each stored tag with bits 31:8. A hit completes in the same cycle. On a miss, a three-state controller waits two cycles for the memory read. In its last state it writes the returned doubleword into the victim way and forwards the requested half to the processor in the same cycle. The memory address output is always the fetch address without its low three bits, so a single memory read refills a whole line. The processor holds the fetch address steady until the ready flag rises.

Top module: `icache2w`

## Requirements
- R1: Bit 2 of the fetch address picks the word returned from a line: 0 gives bits 31:0 of the line and 1 gives bits 63:32. Address bits 1:0 have no effect on the result.
- R2: When a valid line in either way of set `fetch_addr[7:3]` holds tag `fetch_addr[31:8]`, `instr_ready` is 1 in that same cycle and `instr` carries the cached word.
- R3: On a miss, `instr_ready` is 0 in the request cycle and in the following cycle. It is 1 in the third cycle, and `instr` then carries the word taken from `mem_rdata`.
- R4: `mem_addr` always equals `fetch_addr[31:3]`.
- R5: A refill writes valid=1, the tag and the memory doubleword into the way marked least recently used: way 0 when the set's bit is 0, way 1 when it is 1. Later fetches to that line hit, and at most one way ever hits.
- R6: Each completed fetch updates its set's replacement bit. Finishing on way 0, by a hit or by a refill, sets the bit to 1. Finishing on way 1 clears it to 0.
- R7: While `rst` is 1, `instr_ready` is 0. Reset clears every valid bit and every replacement bit, so after reset the first access to any set misses and fills way 0.
- R8: The controller always steps from its idle state to the first wait state on a miss, then to the second wait state, then back to idle. The cache arrays are written only in the second wait state.
- R9: The following sequence gives the stated outcomes: 0x000 miss, 0x004 hit, 0x100 miss (fills way 1), 0x004 hit, 0x104 hit, 0x204 miss (evicts way 0), 0x104 hit, 0x3FC miss, 0x100 hit, 0x200 hit, 0x3F8 hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | 32 | Instruction byte address, valid every cycle |
| instr | output | 32 | Fetched instruction word, meaningful when `instr_ready` is 1 |
| instr_ready | output | 1 | Fetch completes this cycle |
| mem_addr | output | 29 | Doubleword address sent to main memory |
| mem_rdata | input | 64 | Read data returned by main memory |

## Verification
The hardest state to reach is a set where both ways are valid and a third tag arrives. The victim then depends on the whole history of hits and refills in that set, not only on the last refill. Random fetches are therefore drawn from four tags spread over only four sets. This produces frequent conflicts and mixed orders of hits and evictions. A reference model in the bench tracks valid bits, tags and replacement bits, and predicts hit or miss for every fetch. A reset in the middle of the run, followed by fetches to lines that were cached before it, shows that every valid bit was cleared.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_WAIT2 = 2'd2
  } fill_state_e;
endpackage

// File: rtl/icache_way.sv
// One way: tag and data arrays (asynchronous read, synchronous write)
// plus a resettable valid vector and the tag comparator.
module icache_way #(
  parameter int IDX_W  = 5,
  parameter int TAG_W  = 24,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic              hit,
  output logic [LINE_W-1:0] rd_line
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [LINE_W-1:0] line_mem [DEPTH];
  logic [DEPTH-1:0]  valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        valid_q         <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  assign rd_line = line_mem[rd_idx];
  assign hit     = !rst && valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
endmodule

// File: rtl/icache_lru.sv
// One replacement bit per set: 1 means way 1 is least recently used.
module icache_lru #(
  parameter int IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      idx,
  input  logic                  upd,
  input  logic                  used_way1,
  output logic                  victim_way1,
  output logic [(1<<IDX_W)-1:0] lru_bits
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst)      lru_q      <= '0;
    else if (upd) lru_q[idx] <= ~used_way1;
  end

  assign victim_way1 = lru_q[idx];
  assign lru_bits    = lru_q;
endmodule

// File: rtl/icache_ctrl.sv
// Three-state refill controller.
module icache_ctrl
  import icache_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        miss,
  output fill_state_e state,
  output logic        ready,
  output logic        fill_en
);
  fill_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    ready   = 1'b0;
    fill_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ready = !miss;
        if (miss) state_d = ST_WAIT1;
      end
      ST_WAIT1: state_d = ST_WAIT2;
      ST_WAIT2: begin
        ready   = 1'b1;
        fill_en = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/icache2w.sv
module icache2w
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [ADDR_W-1:0]                       fetch_addr,
  output logic [WORD_W-1:0]                       instr,
  output logic                                    instr_ready,
  output logic [ADDR_W-$clog2(WORD_W/8)-2:0]      mem_addr,
  input  logic [2*WORD_W-1:0]                     mem_rdata
);
  localparam int OFF_W   = $clog2(WORD_W/8);
  localparam int WSEL    = OFF_W;
  localparam int IDX_LO  = OFF_W + 1;
  localparam int TAG_LO  = IDX_LO + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LO;
  localparam int LINE_W  = 2 * WORD_W;
  localparam int DEPTH   = 1 << IDX_W;

  logic [IDX_W-1:0]  line_idx;
  logic [TAG_W-1:0]  line_tag;
  logic              word_hi;
  logic [1:0]        hit_w;
  logic [LINE_W-1:0] way_line [2];
  logic              miss;
  logic              fill_en;
  logic              victim_way1;
  logic              used_way1;
  logic [DEPTH-1:0]  lru_bits;
  logic [LINE_W-1:0] sel_line;
  fill_state_e       fsm_state;
  logic              byte_off_unused;

  assign line_idx        = fetch_addr[TAG_LO-1:IDX_LO];
  assign line_tag        = fetch_addr[ADDR_W-1:TAG_LO];
  assign word_hi         = fetch_addr[WSEL];
  assign byte_off_unused = ^fetch_addr[OFF_W-1:0];
  assign mem_addr        = fetch_addr[ADDR_W-1:IDX_LO];

  for (genvar w = 0; w < 2; w++) begin : g_way
    icache_way #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .LINE_W(LINE_W)
    ) way_i (
      .clk    (clk),
      .rst    (rst),
      .rd_idx (line_idx),
      .rd_tag (line_tag),
      .wr_en  (fill_en && (victim_way1 == (w == 1))),
      .wr_idx (line_idx),
      .wr_tag (line_tag),
      .wr_line(mem_rdata),
      .hit    (hit_w[w]),
      .rd_line(way_line[w])
    );
  end

  assign miss = ~|hit_w;

  icache_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .miss   (miss),
    .state  (fsm_state),
    .ready  (instr_ready),
    .fill_en(fill_en)
  );

  assign used_way1 = fill_en ? victim_way1 : hit_w[1];

  icache_lru #(.IDX_W(IDX_W)) lru_i (
    .clk        (clk),
    .rst        (rst),
    .idx        (line_idx),
    .upd        (instr_ready),
    .used_way1  (used_way1),
    .victim_way1(victim_way1),
    .lru_bits   (lru_bits)
  );

  always_comb begin
    if (fill_en)       sel_line = mem_rdata;
    else if (hit_w[1]) sel_line = way_line[1];
    else               sel_line = way_line[0];
  end

  assign instr = word_hi ? sel_line[LINE_W-1:WORD_W] : sel_line[WORD_W-1:0];
endmodule

// File: rtl/icache2w_chk.sv
module icache2w_chk
  import icache_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ready,
  input fill_state_e           st,
  input logic [1:0]            hits,
  input logic [IDX_W-1:0]      idx,
  input logic [(1<<IDX_W)-1:0] lru_bits
);
  // R8: wait states always advance in order
  p_seq_wait1_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT1) |=> (st == ST_WAIT2));
  p_seq_wait2_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT2) |=> (st == ST_IDLE));

  // R3: never more than two consecutive not-ready cycles
  p_miss_len_r3: assert property (@(posedge clk) disable iff (rst)
    (!ready && $past(!ready) && !$past(rst)) |=> ready);

  // R5: the two ways never hold the same line
  p_one_hit_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hits));

  // R6: a hit in way 0 marks way 1 as victim; a refill flips the bit
  p_lru_hit0_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && ready && hits[0]) |=> lru_bits[$past(idx)]);
  p_lru_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT2) |=> (lru_bits[$past(idx)] == !$past(lru_bits[idx])));

  // R7: first cycle out of reset is idle and cannot hit
  p_clear_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st == ST_IDLE && hits == 2'b00));
endmodule

bind icache2w icache2w_chk #(.IDX_W(IDX_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .ready   (instr_ready),
  .st      (fsm_state),
  .hits    (hit_w),
  .idx     (line_idx),
  .lru_bits(lru_bits)
);

// File: tb/icache2w_tb_top.sv
module icache2w_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_addr = '0;
  logic [31:0] instr;
  logic        instr_ready;
  logic [28:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic [28:0] mem_a1 = '0;

  int checks = 0;
  int errors = 0;

  // reference model
  logic        m_val [2][32];
  logic [23:0] m_tag [2][32];
  logic        m_lru [32];

  always #10 clk = ~clk;

  icache2w dut_i (
    .clk        (clk),
    .rst        (rst),
    .fetch_addr (fetch_addr),
    .instr      (instr),
    .instr_ready(instr_ready),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata)
  );

  function automatic logic [63:0] mem_line(input logic [28:0] d);
    logic [31:0] dd;
    dd = {3'b000, d};
    return {dd * 32'h0001_0003 ^ 32'h5A5A_0000, dd * 32'h0000_0007 + 32'h0000_1234};
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    logic [63:0] l;
    l = mem_line(a[31:3]);
    return a[2] ? l[63:32] : l[31:0];
  endfunction

  // two-cycle memory
  always @(posedge clk) begin
    mem_a1    <= mem_addr;
    mem_rdata <= mem_line(mem_a1);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 32; i++) begin
      m_val[0][i] = 1'b0;
      m_val[1][i] = 1'b0;
      m_lru[i]    = 1'b0;
    end
  endtask

  // entered at a negedge; returns at a negedge. kind: 0 any, 1 hit, 2 miss
  task automatic fetch(input logic [31:0] a, input int kind, input string req);
    int hw;
    logic [4:0]  ix;
    logic [23:0] tg;
    ix = a[7:3];
    tg = a[31:8];
    hw = -1;
    for (int w = 0; w < 2; w++)
      if (m_val[w][ix] && m_tag[w][ix] == tg) hw = w;
    fetch_addr = a;
    #1;
    chk(mem_addr == a[31:3], "R4", 64'(mem_addr), 64'(a[31:3]));
    if (kind == 1) chk(hw >= 0, req, 64'(hw), 64'(1));
    if (kind == 2) chk(hw < 0, req, 64'(hw), 64'(0));
    if (hw >= 0) begin
      chk(instr_ready == 1'b1, "R2", 64'(instr_ready), 64'(1));
      chk(instr == exp_word(a), "R2 R1", 64'(instr), 64'(exp_word(a)));
      m_lru[ix] = (hw == 0);
      @(negedge clk);
    end else begin
      chk(instr_ready == 1'b0, "R3", 64'(instr_ready), 64'(0));
      @(negedge clk); #1;
      chk(instr_ready == 1'b0, "R3", 64'(instr_ready), 64'(0));
      @(negedge clk); #1;
      chk(instr_ready == 1'b1, "R3", 64'(instr_ready), 64'(1));
      chk(instr == exp_word(a), "R3 R1", 64'(instr), 64'(exp_word(a)));
      hw = m_lru[ix] ? 1 : 0;   // R5: victim from replacement bit
      m_val[hw][ix] = 1'b1;
      m_tag[hw][ix] = tg;
      m_lru[ix]     = (hw == 0); // R6
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(instr_ready == 1'b0, "R7", 64'(instr_ready), 64'(0));
    end
    model_clear();
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd1234));
    model_clear();
    do_reset();

    // R9 directed sequence
    fetch(32'h000, 2, "R9 R7");
    fetch(32'h004, 1, "R9");
    fetch(32'h100, 2, "R9");
    fetch(32'h004, 1, "R9 R6");
    fetch(32'h104, 1, "R9 R5");
    fetch(32'h204, 2, "R9 R5");
    fetch(32'h104, 1, "R9 R6");
    fetch(32'h3FC, 2, "R9 R7");
    fetch(32'h100, 1, "R9");
    fetch(32'h200, 1, "R9");
    fetch(32'h3F8, 1, "R9");

    // R1: low byte-offset bits ignored
    fetch(32'h203, 1, "R1");
    fetch(32'h3FD, 1, "R1");

    // R6/R8: three tags cycling in one set
    fetch(32'h1040, 2, "R8");
    fetch(32'h2040, 2, "R8");
    fetch(32'h1044, 1, "R6");
    fetch(32'h3040, 2, "R6 R5");
    fetch(32'h1040, 1, "R6");
    fetch(32'h2040, 2, "R6");

    // R7: mid-run reset clears valid bits
    @(negedge clk);
    do_reset();
    fetch(32'h004, 2, "R7");
    fetch(32'h104, 2, "R7");
    fetch(32'h000, 1, "R7");

    // constrained random: 4 tags x 4 sets, random word/byte bits
    for (int n = 0; n < 800; n++) begin
      a = {22'(0), 2'($urandom % 4), 3'b000, 2'($urandom % 4), 3'($urandom % 8)};
      fetch(a, 0, "R5 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule